// File: doc/BRIEF.md
# Sharer-Vector Coherence Directory Bank

This block is the coherence bookkeeping for one bank of an inclusive shared last-level cache. It serves a configurable number of private caches. For every set it records a tag, a stable state (Invalid, Shared or Modified) and one presence bit per core. The presence bits are exact, because every private cache reports each replacement it makes, including clean ones. From this record the controller sends only the protocol messages a request actually needs. It supplies data to a requester. It forwards a request to the current owner. It invalidates readers before a write. It recalls every private copy before it reuses a slot for a different block.

Requests arrive on one valid/ready port, tagged with the requesting core and an operation: read, write, clean eviction or dirty eviction. Outgoing messages leave on a single registered port that pulses for one cycle. Each message carries a type, a multicast destination mask, the block address, the requester id and a size in bytes. Acknowledgements from the private caches arrive on a separate port, one per cycle. While a forward, an invalidation round or a recall is outstanding, the controller holds its ready low. A stalled request is therefore held at the port, never dropped.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every set is Invalid, `req_ready_o` is high and `msg_valid_o` is low. The first read or write to any address is answered with data and causes no recall or forward.
- R2: A read to a block that is Invalid or Shared is answered one cycle after acceptance by a data message to the requester alone. The block becomes Shared with the requester's bit added. Bit i of every core mask stands for core i.
- R3: A write to an Invalid block, or to a block already Modified at the writer, is answered with data to the writer. The block is then Modified with only the writer's bit set.
- R4: A write to a Shared block that other cores hold sends one invalidation, multicast to exactly the other holders. The requester then stalls until each of those cores has acknowledged once. The cycle after the last acknowledgement, data goes to the writer and the block becomes Modified at the writer.
- R5: A write to a block Modified at another core sends a forward to the owner carrying the requester id. After the owner's acknowledgement the block is Modified at the requester only, and the directory itself sends no data.
- R6: A read to a block Modified at another core sends a forward to the owner. After the owner's cleanup acknowledgement the block is Shared with both the owner's and the requester's bits set.
- R7: A clean or dirty eviction is answered with an acknowledgement to the evicting core and clears that core's bit. When no holder remains the block becomes Invalid. An eviction of an absent block is still acknowledged and changes nothing.
- R8: A read or write whose set holds a different valid block first sends a recall, multicast to exactly that block's holders and carrying the victim's address. Only after all of those holders have acknowledged is the new block installed and served with data.
- R9: While any forward, invalidation or recall is outstanding, `req_ready_o` is low. An acknowledgement from a core that was not targeted, or a second one from a core that already answered, does not count toward completion.
- R10: Message type codes are data 0, forward 1, invalidation 2, recall 3 and acknowledgement 4. Data messages report 72 bytes and all others report 8. A message appears in the cycle after the accepting edge or after the last-acknowledgement edge, and stays for exactly one cycle.
- R11: The low `IDX_W` bits of the address select the set and the remaining bits form the tag. Blocks that share a tag but differ in set do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_core_i | input | CORE_W | Requesting core |
| req_op_i | input | 2 | 0 read, 1 write, 2 clean eviction, 3 dirty eviction |
| req_addr_i | input | TAG_W+IDX_W | Block address |
| ack_valid_i | input | 1 | Acknowledgement present |
| ack_core_i | input | CORE_W | Core sending the acknowledgement |
| msg_valid_o | output | 1 | Outgoing message present |
| msg_type_o | output | 3 | Message type code |
| msg_dest_o | output | N_CORES | Destination core mask |
| msg_req_core_o | output | CORE_W | Original requester carried by the message |
| msg_addr_o | output | TAG_W+IDX_W | Block address of the message |
| msg_bytes_o | output | 7 | Message size in bytes |

## Verification
The bench targets the places where sharer tracking can go stale. Invalidations must be masked to the other holders and exclude the writer. After a read forwarded to an owner, both owner and requester must remain tracked. A design that forgot either would later invalidate the wrong cores or miss one. Stray and duplicate acknowledgements are injected during an invalidation round; a counter that took them would release the requester early and hand out data while copies survive. Victim replacement is driven twice in the same set, and the recall must name the old address and every holder; a design that reused the slot at once would break inclusion. A last-holder eviction must leave the block Invalid, so a later write returns data rather than a forward to a departed owner.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} coh_state_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EVC = 2'd2, OP_EVD = 2'd3} req_op_e;
  typedef enum logic [2:0] {
    MSG_DATA = 3'd0, MSG_FWD = 3'd1, MSG_INV = 3'd2, MSG_RECALL = 3'd3, MSG_ACK = 3'd4
  } msg_type_e;
  typedef enum logic [2:0] {
    E_IDLE = 3'd0, E_FWD_RD = 3'd1, E_FWD_WR = 3'd2, E_INV = 3'd3, E_RECALL = 3'd4
  } eng_state_e;
  localparam int unsigned CTRL_BYTES = 8;
  localparam int unsigned DATA_BYTES = 72;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_SETS  = 4,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output coh_state_e         rd_state_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [N_CORES-1:0] rd_sharers_o,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  coh_state_e         wr_state_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [N_CORES-1:0] wr_sharers_i
);
  coh_state_e         st_q  [N_SETS];
  logic [TAG_W-1:0]   tag_q [N_SETS];
  logic [N_CORES-1:0] sh_q  [N_SETS];

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[s]  <= ST_I;
        tag_q[s] <= '0;
        sh_q[s]  <= '0;
      end else if (we_i && (wr_idx_i == IDX_W'(s))) begin
        st_q[s]  <= wr_state_i;
        tag_q[s] <= wr_tag_i;
        sh_q[s]  <= wr_sharers_i;
      end
    end
  end

  assign rd_state_o   = st_q[rd_idx_i];
  assign rd_tag_o     = tag_q[rd_idx_i];
  assign rd_sharers_o = sh_q[rd_idx_i];

  a_r3_m_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_state_i == ST_M) |-> $onehot(wr_sharers_i));
  a_r2_s_has_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_state_i == ST_S) |-> (wr_sharers_i != '0));
  a_r7_i_no_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_state_i == ST_I) |-> (wr_sharers_i == '0));
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter int N_CORES = 4,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int CNT_W  = $clog2(N_CORES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N_CORES-1:0] load_mask_i,
  input  logic               ack_valid_i,
  input  logic [CORE_W-1:0]  ack_core_i,
  output logic [N_CORES-1:0] pending_o,
  output logic               done_o
);
  logic [N_CORES-1:0] pending_q;
  logic [CNT_W-1:0]   cnt_q, pop;
  logic               hit;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N_CORES; i++) pop = pop + CNT_W'(load_mask_i[i]);
  end

  // only acks from still-pending targets count
  assign hit       = ack_valid_i && !load_i && pending_q[ack_core_i];
  assign done_o    = hit && (cnt_q == CNT_W'(1));
  assign pending_o = pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      cnt_q     <= '0;
    end else if (load_i) begin
      pending_q <= load_mask_i;
      cnt_q     <= pop;
    end else if (hit) begin
      pending_q <= pending_q & ~(N_CORES'(1) << ack_core_i);
      cnt_q     <= cnt_q - CNT_W'(1);
    end
  end

  a_r9_cnt_tracks_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_W'($countones(pending_q)));
  a_r9_stray_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && !load_i && !pending_q[ack_core_i]) |=> $stable(cnt_q));
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_SETS  = 4,
  parameter int TAG_W   = 6,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IDX_W  = (N_SETS > 1) ? $clog2(N_SETS) : 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [CORE_W-1:0]  req_core_i,
  input  logic [1:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               ack_valid_i,
  input  logic [CORE_W-1:0]  ack_core_i,
  output logic               msg_valid_o,
  output logic [2:0]         msg_type_o,
  output logic [N_CORES-1:0] msg_dest_o,
  output logic [CORE_W-1:0]  msg_req_core_o,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [6:0]         msg_bytes_o
);
  eng_state_e eng_q, eng_d;

  logic [IDX_W-1:0]   req_idx, p_idx_q, rd_idx;
  logic [TAG_W-1:0]   req_tag, p_tag_q, rd_tag;
  coh_state_e         rd_state;
  logic [N_CORES-1:0] rd_sh, p_sh_q, req_bit, p_bit, others, remain;
  logic [CORE_W-1:0]  p_core_q;
  req_op_e            op, p_op_q;
  logic               accept, hit;

  logic               we;
  logic [IDX_W-1:0]   w_idx;
  coh_state_e         w_state;
  logic [TAG_W-1:0]   w_tag;
  logic [N_CORES-1:0] w_sh;

  logic               ld, trk_done;
  logic [N_CORES-1:0] ld_mask, trk_pending;

  logic               mv_d;
  msg_type_e          mt_d;
  logic [N_CORES-1:0] md_d;
  logic [CORE_W-1:0]  mr_d;
  logic [ADDR_W-1:0]  ma_d;

  assign req_idx     = req_addr_i[IDX_W-1:0];
  assign req_tag     = req_addr_i[ADDR_W-1:IDX_W];
  assign op          = req_op_e'(req_op_i);
  assign req_ready_o = (eng_q == E_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rd_idx      = req_ready_o ? req_idx : p_idx_q;
  assign req_bit     = N_CORES'(1) << req_core_i;
  assign p_bit       = N_CORES'(1) << p_core_q;
  assign hit         = (rd_state != ST_I) && (rd_tag == req_tag);
  assign others      = rd_sh & ~req_bit;
  assign remain      = rd_sh & ~req_bit;

  dir_store #(.N_CORES(N_CORES), .N_SETS(N_SETS), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_state_o(rd_state), .rd_tag_o(rd_tag), .rd_sharers_o(rd_sh),
    .we_i(we), .wr_idx_i(w_idx), .wr_state_i(w_state), .wr_tag_i(w_tag), .wr_sharers_i(w_sh)
  );

  ack_tracker #(.N_CORES(N_CORES)) u_trk (
    .clk_i, .rst_ni,
    .load_i(ld), .load_mask_i(ld_mask),
    .ack_valid_i, .ack_core_i,
    .pending_o(trk_pending), .done_o(trk_done)
  );

  always_comb begin
    eng_d   = eng_q;
    we      = 1'b0;
    w_idx   = req_idx;
    w_state = rd_state;
    w_tag   = req_tag;
    w_sh    = rd_sh;
    ld      = 1'b0;
    ld_mask = '0;
    mv_d    = 1'b0;
    mt_d    = MSG_DATA;
    md_d    = req_bit;
    mr_d    = req_core_i;
    ma_d    = req_addr_i;
    if (accept) begin
      if (!hit && rd_state != ST_I && (op == OP_RD || op == OP_WR)) begin
        // victim still held privately: recall before reuse
        mv_d    = 1'b1;
        mt_d    = MSG_RECALL;
        md_d    = rd_sh;
        ma_d    = {rd_tag, req_idx};
        ld      = 1'b1;
        ld_mask = rd_sh;
        eng_d   = E_RECALL;
      end else if (!hit) begin
        mv_d = 1'b1;
        unique case (op)
          OP_RD:   begin we = 1'b1; w_state = ST_S; w_sh = req_bit; mt_d = MSG_DATA; end
          OP_WR:   begin we = 1'b1; w_state = ST_M; w_sh = req_bit; mt_d = MSG_DATA; end
          default: mt_d = MSG_ACK;
        endcase
      end else begin
        unique case (op)
          OP_RD: begin
            if (rd_state == ST_M && rd_sh != req_bit) begin
              mv_d = 1'b1; mt_d = MSG_FWD; md_d = rd_sh;
              ld = 1'b1; ld_mask = rd_sh; eng_d = E_FWD_RD;
            end else begin
              mv_d = 1'b1; mt_d = MSG_DATA;
              if (rd_state != ST_M) begin
                we = 1'b1; w_state = ST_S; w_sh = rd_sh | req_bit;
              end
            end
          end
          OP_WR: begin
            mv_d = 1'b1;
            if (others != '0) begin
              mt_d    = (rd_state == ST_M) ? MSG_FWD : MSG_INV;
              md_d    = others;
              ld      = 1'b1;
              ld_mask = others;
              eng_d   = (rd_state == ST_M) ? E_FWD_WR : E_INV;
            end else begin
              mt_d = MSG_DATA; we = 1'b1; w_state = ST_M; w_sh = req_bit;
            end
          end
          default: begin
            mv_d = 1'b1; mt_d = MSG_ACK;
            we = 1'b1; w_sh = remain;
            w_state = (remain == '0) ? ST_I : rd_state;
          end
        endcase
      end
    end else if (eng_q != E_IDLE && trk_done) begin
      eng_d = E_IDLE;
      we    = 1'b1;
      w_idx = p_idx_q;
      w_tag = p_tag_q;
      mr_d  = p_core_q;
      md_d  = p_bit;
      ma_d  = {p_tag_q, p_idx_q};
      unique case (eng_q)
        E_FWD_RD: begin w_state = ST_S; w_sh = p_sh_q | p_bit; end
        E_FWD_WR: begin w_state = ST_M; w_sh = p_bit; end
        E_INV:    begin w_state = ST_M; w_sh = p_bit; mv_d = 1'b1; mt_d = MSG_DATA; end
        default: begin
          // recall done: install the new block from Invalid
          w_state = (p_op_q == OP_WR) ? ST_M : ST_S;
          w_sh    = p_bit;
          mv_d    = 1'b1;
          mt_d    = MSG_DATA;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_q    <= E_IDLE;
      p_core_q <= '0;
      p_op_q   <= OP_RD;
      p_tag_q  <= '0;
      p_idx_q  <= '0;
      p_sh_q   <= '0;
    end else begin
      eng_q <= eng_d;
      if (accept) begin
        p_core_q <= req_core_i;
        p_op_q   <= op;
        p_tag_q  <= req_tag;
        p_idx_q  <= req_idx;
        p_sh_q   <= rd_sh;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o    <= 1'b0;
      msg_type_o     <= MSG_DATA;
      msg_dest_o     <= '0;
      msg_req_core_o <= '0;
      msg_addr_o     <= '0;
    end else begin
      msg_valid_o    <= mv_d;
      msg_type_o     <= mt_d;
      msg_dest_o     <= md_d;
      msg_req_core_o <= mr_d;
      msg_addr_o     <= ma_d;
    end
  end

  assign msg_bytes_o = (msg_type_o == MSG_DATA) ? 7'(DATA_BYTES) : 7'(CTRL_BYTES);

  a_r4_targets_tracked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && (msg_type_o == MSG_INV || msg_type_o == MSG_FWD || msg_type_o == MSG_RECALL))
      |-> (trk_pending == msg_dest_o));
  a_r8_recall_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_RECALL) |-> (msg_dest_o != '0));
  a_r2_data_unicast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == MSG_DATA) |-> $onehot(msg_dest_o));
  a_r9_release_on_last_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(req_ready_o) && req_ready_o) |-> $past(trk_done));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !req_ready_o) |=> !msg_valid_o);
endmodule

// File: tb/dir_ctrl_tb_top.sv
module dir_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_core = '0;
  logic [1:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic       ack_valid = 1'b0;
  logic [1:0] ack_core = '0;
  logic       msg_valid;
  logic [2:0] msg_type;
  logic [3:0] msg_dest;
  logic [1:0] msg_req;
  logic [7:0] msg_addr;
  logic [6:0] msg_bytes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_core_i(req_core),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .ack_valid_i(ack_valid), .ack_core_i(ack_core),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dest_o(msg_dest),
    .msg_req_core_o(msg_req), .msg_addr_o(msg_addr), .msg_bytes_o(msg_bytes)
  );

  // op codes: 0 read, 1 write, 2 clean evict, 3 dirty evict
  // msg codes: 0 data, 1 fwd, 2 inv, 3 recall, 4 ack
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] core;
    logic [1:0] op;
    logic [7:0] addr;
    logic [2:0] ty;
    logic [3:0] dest;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'd1, 2'd0, 8'h21, 3'd0, 4'b0010},  // R2 read Invalid
    '{4'd2,  2'd2, 2'd0, 8'h21, 3'd0, 4'b0100},  // R2 read Shared
    '{4'd2,  2'd3, 2'd0, 8'h21, 3'd0, 4'b1000},  // R2 third reader
    '{4'd3,  2'd0, 2'd1, 8'h10, 3'd0, 4'b0001},  // R3 write Invalid
    '{4'd7,  2'd3, 2'd2, 8'h21, 3'd4, 4'b1000},  // R7 clean evict
    '{4'd3,  2'd0, 2'd1, 8'h10, 3'd0, 4'b0001},  // R3 write own M
    '{4'd7,  2'd0, 2'd3, 8'h10, 3'd4, 4'b0001},  // R7 dirty evict, last holder
    '{4'd7,  2'd2, 2'd1, 8'h10, 3'd0, 4'b0100}   // R7 block Invalid: data, no fwd
  };

  task automatic send_req(input int core, input int op, input logic [7:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(core); req_op = 2'(op); req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ack(input int core);
    @(negedge clk);
    ack_valid = 1'b1; ack_core = 2'(core);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic check_msg(input int r, input bit v, input int ty, input logic [3:0] dest,
                           input logic [7:0] addr);
    bit ok;
    int eb;
    eb = (ty == 0) ? 72 : 8;
    checks++;
    ok = (msg_valid == v);
    if (v) ok = ok && msg_type == 3'(ty) && msg_dest == dest && msg_addr == addr
                   && int'(msg_bytes) == eb;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got v=%0b t=%0d d=%b a=%h b=%0d, exp v=%0b t=%0d d=%b a=%h b=%0d",
               r, msg_valid, msg_type, msg_dest, msg_addr, msg_bytes, v, ty, dest, addr, eb);
    end
  endtask

  task automatic check_ready(input int r, input bit exp);
    checks++;
    if (req_ready !== exp) begin
      fails++;
      $display("FAIL R%0d: ready got %0b exp %0b", r, req_ready, exp);
    end
  endtask

  task automatic check_req_core(input int r, input int exp);
    checks++;
    if (int'(msg_req) != exp) begin
      fails++;
      $display("FAIL R%0d: requester got %0d exp %0d", r, msg_req, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles exp below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_ready(1, 1'b1);
    check_msg(1, 1'b0, 0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      send_req(int'(VECS[i].core), int'(VECS[i].op), VECS[i].addr);
      check_msg(int'(VECS[i].req), 1'b1, int'(VECS[i].ty), VECS[i].dest, VECS[i].addr);
    end
    // now 0x21 Shared {1,2}, 0x10 Modified at core 2

    send_req(0, 0, 8'h21);                  // R2
    check_msg(2, 1'b1, 0, 4'b0001, 8'h21);

    send_req(1, 1, 8'h21);                  // R4 invalidate others {0,2}
    check_msg(4, 1'b1, 2, 4'b0101, 8'h21);
    check_ready(9, 1'b0);
    send_ack(3);                            // R9 stray
    check_msg(9, 1'b0, 0, '0, '0);
    check_ready(9, 1'b0);
    send_ack(0);
    check_ready(4, 1'b0);
    send_ack(0);                            // R9 duplicate
    check_ready(9, 1'b0);
    send_ack(2);
    check_msg(4, 1'b1, 0, 4'b0010, 8'h21);
    check_ready(4, 1'b1);

    send_req(0, 0, 8'h21);                  // R6 read of M at core 1
    check_msg(6, 1'b1, 1, 4'b0010, 8'h21);
    check_req_core(6, 0);
    send_ack(1);
    check_msg(6, 1'b0, 0, '0, '0);
    check_ready(6, 1'b1);
    send_req(3, 1, 8'h21);                  // R6 both bits kept
    check_msg(6, 1'b1, 2, 4'b0011, 8'h21);
    send_ack(0);
    send_ack(1);
    check_msg(4, 1'b1, 0, 4'b1000, 8'h21);

    send_req(2, 1, 8'h21);                  // R5 write of M at core 3
    check_msg(5, 1'b1, 1, 4'b1000, 8'h21);
    check_req_core(5, 2);
    send_ack(3);
    check_msg(5, 1'b0, 0, '0, '0);
    check_ready(5, 1'b1);
    send_req(0, 1, 8'h21);                  // R5 ownership moved to core 2
    check_msg(5, 1'b1, 1, 4'b0100, 8'h21);
    send_ack(2);
    check_ready(5, 1'b1);

    send_req(1, 0, 8'h30);                  // R8 victim 0x10 at core 2
    check_msg(8, 1'b1, 3, 4'b0100, 8'h10);
    check_ready(8, 1'b0);
    send_ack(2);
    check_msg(8, 1'b1, 0, 4'b0010, 8'h30);
    send_req(3, 0, 8'h30);                  // R2
    check_msg(2, 1'b1, 0, 4'b1000, 8'h30);
    send_req(0, 0, 8'h10);                  // R8 recall both readers
    check_msg(8, 1'b1, 3, 4'b1010, 8'h30);
    send_ack(1);
    check_ready(8, 1'b0);
    send_ack(3);
    check_msg(8, 1'b1, 0, 4'b0001, 8'h10);

    send_req(2, 2, 8'h22);                  // R7 evict absent block
    check_msg(7, 1'b1, 4, 4'b0100, 8'h22);

    send_req(1, 0, 8'h13);                  // R11 same tag, other set: no recall
    check_msg(11, 1'b1, 0, 4'b0010, 8'h13);
    @(negedge clk);                         // R10 one-cycle pulse
    check_msg(10, 1'b0, 0, '0, '0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_ready(1, 1'b1);
    send_req(1, 1, 8'h10);                  // R1 directory cleared
    check_msg(1, 1'b1, 0, 4'b0010, 8'h10);

    finish_run();
  end
endmodule